// File: doc/BRIEF.md
# Stochastic Learning Synapse Weight Counter

This block is a single synapse of a small, fully connected network of binary stochastic neurons. It keeps one connection strength in sign-magnitude form: a sign bit and a four-bit magnitude, giving a range of -15 to +15. A separate negative-zero code means the link is switched off.

Learning takes two phases. In the clamped phase the teacher holds the output neurons in the correct state. In the free phase those neurons run on their own. At the end of each anneal interval a correlate strobe records whether the two neurons the synapse joins are in the same state. Each phase writes its own held bit. An adjust strobe then compares the two bits. The weight moves up by one when only the clamped phase agreed, moves down by one when only the free phase agreed, and stays put when both phases gave the same result.

A decay strobe pulls the weight down by one, which keeps weights from growing without limit. The five weight flip-flops also form a scan chain, so a weight can be loaded serially or read out destructively.

Top module: `syn_weight_cell`

## Requirements
- R1: After synchronous reset, `weight_out` is 0, `link_en` is 1 and `scan_out` is 0. The stored weight is positive zero: sign bit 0, magnitude 0.
- R2: On a `corr_stb` pulse the cell records agreement, meaning `nrn_a == nrn_b`. The result goes into the clamped-phase bit when `teach_phase` is 1 and into the free-phase bit when it is 0.
- R3: An `adj_stb` pulse adds one to the weight when the clamped-phase bit is set and the free-phase bit is clear.
- R4: An `adj_stb` pulse subtracts one from the weight when the free-phase bit is set and the clamped-phase bit is clear.
- R5: An `adj_stb` pulse leaves the weight unchanged when both bits are equal. Both held bits clear on every `adj_stb`, so a second adjust with no new correlate pulses changes nothing.
- R6: Counting saturates. An increment at +15 and a decrement at -15 leave the weight where it is.
- R7: Counting never produces negative zero. Stepping up from -1 gives +0, and stepping down from +0 gives -1.
- R8: A `decay_stb` pulse subtracts one from the weight. When `adj_stb` is high in the same cycle, the adjust rule alone applies and the decay is dropped.
- R9: While `shift_en` is high, the stored bits {sign, mag[3], mag[2], mag[1], mag[0]} shift toward the sign end, and `scan_in` enters at mag[0]. `scan_out` always shows the sign bit. A value therefore loads sign first and then magnitude from MSB to LSB, and reads out in the same order. Readout is destructive. `shift_en` overrides the adjust and decay strobes.
- R10: When negative zero is stored (sign 1, magnitude 0), `weight_out` is 0 and `link_en` is 0. Adjust and decay pulses have no effect until a new value is shifted in.
- R11: `weight_out` is a 5-bit two's-complement value. It, `link_en` and `scan_out` all change at the same rising edge that samples the strobe acting on the weight. They never change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nrn_a | input | 1 | State of the first neuron |
| nrn_b | input | 1 | State of the second neuron |
| teach_phase | input | 1 | 1 for the clamped phase, 0 for the free phase |
| corr_stb | input | 1 | Sample agreement into the current phase's bit |
| adj_stb | input | 1 | Apply the learning step and clear both held bits |
| decay_stb | input | 1 | Step the weight down by one |
| shift_en | input | 1 | Shift the weight chain by one bit |
| scan_in | input | 1 | Serial data entering at the magnitude LSB |
| weight_out | output | 5 | Signed weight, two's complement; 0 when disconnected |
| link_en | output | 1 | Low when negative zero is stored |
| scan_out | output | 1 | Serial data leaving, equal to the stored sign bit |

## Verification
Every result of this cell appears at the first rising edge after the strobe that causes it. A correlate pulse sets a held bit at that edge. The adjust that follows moves `weight_out` and `link_en` at its own edge. A shift moves `scan_out` at its edge.

The bench drives inputs on falling edges and samples on the next falling edge, which comes half a period after the edge that acts. One dedicated check also looks a quarter period before that edge and confirms that the weight has not yet moved. Serial readout reads `scan_out` before each shift pulse. The value read before the first pulse is therefore the sign bit.

// File: rtl/syn_pkg.sv
package syn_pkg;

  // Operation applied to the weight chain in one cycle
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_INC   = 2'd1,
    OP_DEC   = 2'd2,
    OP_SHIFT = 2'd3
  } wt_op_e;

endpackage

// File: rtl/syn_corr_hold.sv
// Two held agreement bits, one per learning phase.
module syn_corr_hold (
  input  logic clk,
  input  logic rst,
  input  logic nrn_a,
  input  logic nrn_b,
  input  logic teach_phase,
  input  logic corr_stb,
  input  logic adj_stb,
  output logic clamp_q,
  output logic free_q
);

  logic agree;
  assign agree = (nrn_a == nrn_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_q <= 1'b0;
      free_q  <= 1'b0;
    end else if (adj_stb) begin
      // adjust consumes both results
      clamp_q <= 1'b0;
      free_q  <= 1'b0;
    end else if (corr_stb) begin
      if (teach_phase) clamp_q <= agree;
      else             free_q  <= agree;
    end
  end

endmodule

// File: rtl/syn_step_sel.sv
// Picks one weight operation per cycle: shift > adjust > decay.
module syn_step_sel
  import syn_pkg::*;
(
  input  logic   shift_en,
  input  logic   adj_stb,
  input  logic   decay_stb,
  input  logic   clamp_q,
  input  logic   free_q,
  output wt_op_e op
);

  always_comb begin
    op = OP_NONE;
    if (shift_en) begin
      op = OP_SHIFT;
    end else if (adj_stb) begin
      if (clamp_q && !free_q)      op = OP_INC;
      else if (free_q && !clamp_q) op = OP_DEC;
      else                         op = OP_NONE;
    end else if (decay_stb) begin
      op = OP_DEC;
    end
  end

endmodule

// File: rtl/syn_wt_store.sv
// Sign-magnitude store: saturating counter and scan chain in one register.
module syn_wt_store
  import syn_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  wt_op_e             op,
  input  logic               scan_in,
  output logic signed [MAG_W:0] weight_out,
  output logic               link_en,
  output logic               scan_out
);

  localparam int W = MAG_W + 1;
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
  localparam logic [MAG_W-1:0] MAG_ONE = {{(MAG_W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0]     W_ONE   = {{(W-1){1'b0}}, 1'b1};

  logic           sgn_q, sgn_n;
  logic [MAG_W-1:0] mag_q, mag_n;
  logic [W-1:0]   chain_q, chain_sh;
  logic           off_q, off_n;
  logic [W-1:0]   ext_n, wt_n;

  assign chain_q = {sgn_q, mag_q};
  assign off_q   = sgn_q && (mag_q == '0);

  // scan chain: each bit takes its lower neighbour, scan_in enters at bit 0
  genvar gi;
  generate
    for (gi = 1; gi < W; gi++) begin : g_chain
      assign chain_sh[gi] = chain_q[gi-1];
    end
  endgenerate
  assign chain_sh[0] = scan_in;

  always_comb begin
    sgn_n = sgn_q;
    mag_n = mag_q;
    unique case (op)
      OP_SHIFT: begin
        sgn_n = chain_sh[W-1];
        mag_n = chain_sh[MAG_W-1:0];
      end
      OP_INC: begin
        if (!off_q) begin
          if (sgn_q) begin
            if (mag_q == MAG_ONE) begin
              sgn_n = 1'b0;
              mag_n = '0;
            end else begin
              mag_n = mag_q - MAG_ONE;
            end
          end else if (mag_q != MAG_MAX) begin
            mag_n = mag_q + MAG_ONE;
          end
        end
      end
      OP_DEC: begin
        if (!off_q) begin
          if (!sgn_q) begin
            if (mag_q == '0) begin
              sgn_n = 1'b1;
              mag_n = MAG_ONE;
            end else begin
              mag_n = mag_q - MAG_ONE;
            end
          end else if (mag_q != MAG_MAX) begin
            mag_n = mag_q + MAG_ONE;
          end
        end
      end
      default: ;
    endcase
  end

  assign off_n = sgn_n && (mag_n == '0);
  assign ext_n = {1'b0, mag_n};

  always_comb begin
    if (off_n)      wt_n = '0;
    else if (sgn_n) wt_n = (~ext_n) + W_ONE;
    else            wt_n = ext_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sgn_q      <= 1'b0;
      mag_q      <= '0;
      weight_out <= '0;
      link_en    <= 1'b1;
    end else begin
      sgn_q      <= sgn_n;
      mag_q      <= mag_n;
      weight_out <= wt_n;
      link_en    <= !off_n;
    end
  end

  assign scan_out = sgn_q;

endmodule

// File: rtl/syn_weight_cell.sv
module syn_weight_cell
  import syn_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nrn_a,
  input  logic               nrn_b,
  input  logic               teach_phase,
  input  logic               corr_stb,
  input  logic               adj_stb,
  input  logic               decay_stb,
  input  logic               shift_en,
  input  logic               scan_in,
  output logic signed [MAG_W:0] weight_out,
  output logic               link_en,
  output logic               scan_out
);

  logic   clamp_q, free_q;
  wt_op_e op;

  syn_corr_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .nrn_a      (nrn_a),
    .nrn_b      (nrn_b),
    .teach_phase(teach_phase),
    .corr_stb   (corr_stb),
    .adj_stb    (adj_stb),
    .clamp_q    (clamp_q),
    .free_q     (free_q)
  );

  syn_step_sel u_sel (
    .shift_en (shift_en),
    .adj_stb  (adj_stb),
    .decay_stb(decay_stb),
    .clamp_q  (clamp_q),
    .free_q   (free_q),
    .op       (op)
  );

  syn_wt_store #(.MAG_W(MAG_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .scan_in   (scan_in),
    .weight_out(weight_out),
    .link_en   (link_en),
    .scan_out  (scan_out)
  );

endmodule

// File: rtl/syn_weight_chk.sv
module syn_weight_chk #(
  parameter int MAG_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               adj_stb,
  input logic               decay_stb,
  input logic               shift_en,
  input logic signed [MAG_W:0] weight_out,
  input logic               link_en
);

  localparam logic signed [MAG_W:0] WMIN = -((2 ** MAG_W) - 1);
  localparam logic signed [MAG_W:0] WONE = 1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (weight_out == 0) && link_en);

  // R6
  range_bound_chk: assert property (@(posedge clk) disable iff (rst)
    weight_out >= WMIN);

  // R10
  off_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !link_en |-> (weight_out == 0));

  // R10
  off_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_en && !shift_en) |=> !link_en);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !adj_stb && !decay_stb) |=> $stable(weight_out) && $stable(link_en));

  // R8
  decay_step_chk: assert property (@(posedge clk) disable iff (rst)
    (decay_stb && !adj_stb && !shift_en && link_en && weight_out != WMIN)
      |=> (weight_out == $past(weight_out) - WONE));

endmodule

bind syn_weight_cell syn_weight_chk #(.MAG_W(MAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .adj_stb   (adj_stb),
  .decay_stb (decay_stb),
  .shift_en  (shift_en),
  .weight_out(weight_out),
  .link_en   (link_en)
);

// File: tb/syn_weight_cell_tb_top.sv
module syn_weight_cell_tb_top;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst;
  logic nrn_a, nrn_b, teach_phase;
  logic corr_stb, adj_stb, decay_stb, shift_en, scan_in;
  logic signed [4:0] weight_out;
  logic link_en, scan_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  syn_weight_cell #(.MAG_W(4)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .nrn_a      (nrn_a),
    .nrn_b      (nrn_b),
    .teach_phase(teach_phase),
    .corr_stb   (corr_stb),
    .adj_stb    (adj_stb),
    .decay_stb  (decay_stb),
    .shift_en   (shift_en),
    .scan_in    (scan_in),
    .weight_out (weight_out),
    .link_en    (link_en),
    .scan_out   (scan_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_w(input logic sg, input logic [3:0] mg);
    logic [4:0] bits;
    bits = {sg, mg};
    for (int i = 4; i >= 0; i--) begin
      scan_in  = bits[i];
      shift_en = 1'b1;
      @(negedge clk);
    end
    shift_en = 1'b0;
    scan_in  = 1'b0;
  endtask

  task automatic corr(input logic teach, input logic agree);
    teach_phase = teach;
    nrn_a       = 1'b1;
    nrn_b       = agree;
    corr_stb    = 1'b1;
    @(negedge clk);
    corr_stb = 1'b0;
  endtask

  task automatic adj();
    adj_stb = 1'b1;
    @(negedge clk);
    adj_stb = 1'b0;
  endtask

  task automatic decay();
    decay_stb = 1'b1;
    @(negedge clk);
    decay_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 weight", int'(weight_out), 0);
    chk("R1 link_en", int'(link_en), 1);
    chk("R1 scan_out", int'(scan_out), 0);
  endtask

  task automatic t_learn();
    corr(1'b1, 1'b1); corr(1'b0, 1'b0); adj();
    chk("R3 R2 increment", int'(weight_out), 1);
    adj();
    chk("R5 held bits cleared", int'(weight_out), 1);
    corr(1'b1, 1'b0); corr(1'b0, 1'b1); adj();
    chk("R4 decrement", int'(weight_out), 0);
    corr(1'b1, 1'b1); corr(1'b0, 1'b1); adj();
    chk("R5 both agree", int'(weight_out), 0);
    corr(1'b1, 1'b0); corr(1'b0, 1'b0); adj();
    chk("R5 neither agrees", int'(weight_out), 0);
  endtask

  task automatic t_saturate();
    load_w(1'b0, 4'd15);
    chk("R9 load +15", int'(weight_out), 15);
    corr(1'b1, 1'b1); adj();
    chk("R6 top limit", int'(weight_out), 15);
    load_w(1'b1, 4'd15);
    chk("R9 load -15", int'(weight_out), -15);
    corr(1'b0, 1'b1); adj();
    chk("R6 bottom limit", int'(weight_out), -15);
    decay();
    chk("R6 decay at bottom", int'(weight_out), -15);
  endtask

  task automatic t_cross();
    load_w(1'b0, 4'd0);
    decay();
    chk("R7 +0 down", int'(weight_out), -1);
    chk("R7 link on at -1", int'(link_en), 1);
    corr(1'b1, 1'b1); adj();
    chk("R7 -1 up", int'(weight_out), 0);
    chk("R7 link on at +0", int'(link_en), 1);
    chk("R7 sign positive", int'(scan_out), 0);
  endtask

  task automatic t_priority();
    load_w(1'b0, 4'd3);
    corr(1'b1, 1'b1);
    adj_stb = 1'b1; decay_stb = 1'b1;
    @(negedge clk);
    adj_stb = 1'b0; decay_stb = 1'b0;
    chk("R8 adjust beats decay", int'(weight_out), 4);
    decay();
    chk("R8 decay step", int'(weight_out), 3);
  endtask

  task automatic t_scan();
    logic [4:0] exp_bits;
    load_w(1'b1, 4'b1010);
    chk("R9 load -10", int'(weight_out), -10);
    exp_bits = 5'b11010;
    for (int i = 4; i >= 0; i--) begin
      chk("R9 readout bit", int'(scan_out), int'(exp_bits[i]));
      scan_in   = 1'b0;
      shift_en  = 1'b1;
      decay_stb = (i == 4);
      @(negedge clk);
    end
    shift_en = 1'b0; decay_stb = 1'b0;
    chk("R9 destructive readout", int'(weight_out), 0);
    chk("R9 link after readout", int'(link_en), 1);
  endtask

  task automatic t_disc();
    load_w(1'b1, 4'd0);
    chk("R10 weight zero", int'(weight_out), 0);
    chk("R10 link off", int'(link_en), 0);
    decay();
    chk("R10 decay ignored", int'(link_en), 0);
    corr(1'b1, 1'b1); corr(1'b0, 1'b0); adj();
    chk("R10 adjust ignored weight", int'(weight_out), 0);
    chk("R10 adjust ignored link", int'(link_en), 0);
    chk("R10 sign kept", int'(scan_out), 1);
    load_w(1'b0, 4'd5);
    chk("R10 reload", int'(weight_out), 5);
    chk("R10 link back", int'(link_en), 1);
  endtask

  task automatic t_timing();
    decay_stb = 1'b1;
    #(CLK_P/4);
    chk("R11 not before edge", int'(weight_out), 5);
    @(negedge clk);
    decay_stb = 1'b0;
    chk("R11 at edge", int'(weight_out), 4);
  endtask

  initial begin
    rst = 1'b1; nrn_a = 0; nrn_b = 0; teach_phase = 0;
    corr_stb = 0; adj_stb = 0; decay_stb = 0; shift_en = 0; scan_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_learn();
    t_saturate();
    t_cross();
    t_priority();
    t_scan();
    t_disc();
    t_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule